// File: doc/BRIEF.md
# Interleaved Multi-Bank Read Sequencer

This block takes a stream of cache-block read requests and spreads them over a power-of-two number of independent memory banks. Addresses are interleaved on their low bits, so consecutive blocks land in different banks. Every bank keeps its own access timer, which lets a new address go out to an idle bank while other banks are still reading their rows. The effect is that the long row-read latency of several blocks overlaps instead of adding up.

The banks share a single address path and a single data return path. A request is offered with a valid/ready handshake. Requests are issued strictly in order: when the bank a request targets is still occupied, ready stays low until that bank frees up, and no later request may pass it. Once a bank's row read completes, it waits for the shared data path. If several banks are waiting, the path goes to the bank whose request was accepted first. Each block returns as a run of data beats, and a one-cycle response carrying the block address and the beat count follows the final beat. Block contents come from a small behavioural array inside the block.

Top module: `ilv_bank_seq`

## Requirements
- R1: For a block address A, the bank is A mod NBANKS, taken from the low log2(NBANKS) bits of A. The row inside that bank is A div NBANKS, taken from the upper bits.
- R2: `req_ready` is low while the bank addressed by `req_addr` still holds an earlier request. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. Requests are taken in the order they are offered.
- R3: For a request accepted at clock edge t, when the data path is free, the first data beat appears in the cycle that starts at edge t+T_ADDR+T_ROW (t+11 with the defaults). No beat of that block appears earlier.
- R4: A block is returned as exactly T_XFER consecutive cycles of `beat_valid`. Beat k (counting from 0) of block A carries ((A*T_XFER + k) XOR SALT), truncated to DATA_W bits. The defaults are T_XFER=4 and SALT=16'h5A3C.
- R5: The shared address path is occupied for T_ADDR cycles per accepted request. With T_ADDR=1, requests to distinct idle banks are accepted on consecutive clock edges.
- R6: Only one block uses the data path at a time. When one transfer ends, the next waiting bank starts in the following cycle, with no idle gap. Among waiting banks, the one whose request was accepted earliest goes first.
- R7: `rsp_valid` is high for one cycle, in the cycle right after the last beat of a block. In that cycle `rsp_addr` is the block address and `rsp_beats` equals T_XFER.
- R8: A bank can take a new request on the clock edge that ends the cycle carrying its last data beat. A stream aimed at one bank therefore repeats every T_ADDR+T_ROW+T_XFER cycles.
- R9: With the defaults, take 8 blocks at consecutive addresses, offered back to back from idle with the first accepted at edge t. The last response appears in the cycle starting at edge t+43. Take instead 8 blocks that all map to one bank: the last response appears at edge t+120.
- R10: While `rst_n` is low and right after it is released, `req_ready` is high, and `beat_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_addr | input | ADDR_W (6) | Block address of the request |
| req_ready | output | 1 | Request can be taken this cycle |
| beat_valid | output | 1 | A data beat is on `beat_data` |
| beat_data | output | DATA_W (16) | Data beat from the shared return path |
| rsp_valid | output | 1 | One block finished returning |
| rsp_addr | output | ADDR_W (6) | Block address of the finished block |
| rsp_beats | output | $clog2(T_XFER+1) (3) | Number of beats transferred for that block |

## Verification
The hardest case to reach from the ports is a bank being reused at the exact edge its last beat leaves, while several other banks queue for the data path behind it. A wrong cycle there shows up only as a one-cycle shift in ready or in the beats. Random stimulus favours sequential addresses and keeps the request valid most of the time, so the data path stays saturated and the same bank comes around again while its previous block is still draining. Two directed streams then pin down the exact totals: eight distinct banks back to back, and eight requests to a single bank.

// File: rtl/ilv_bank_seq.sv
module ilv_bank_seq #(
  parameter int NBANKS = 8,
  parameter int ROW_W = 3,
  parameter int T_ADDR = 1,
  parameter int T_ROW = 10,
  parameter int T_XFER = 4,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SALT = 16'h5A3C,
  localparam int BANK_W = $clog2(NBANKS),
  localparam int ADDR_W = BANK_W + ROW_W,
  localparam int CNT_W = $clog2(T_XFER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [CNT_W-1:0]  rsp_beats
);

  localparam int BEAT_W = $clog2(T_XFER);
  localparam int TMR_W  = $clog2(T_ADDR + T_ROW);
  localparam int TAG_W  = BANK_W + 1;
  localparam int ABUS_W = $clog2(T_ADDR + 1);
  localparam int DEPTH  = NBANKS * (1 << ROW_W) * T_XFER;
  localparam int IDX_W  = $clog2(DEPTH);

  typedef enum logic [1:0] {PH_IDLE, PH_ROW, PH_XFER} phase_t;

  phase_t            phase  [NBANKS];
  logic [TMR_W-1:0]  timer  [NBANKS];
  logic [ROW_W-1:0]  row_of [NBANKS];
  logic [TAG_W-1:0]  tag    [NBANKS];
  logic [TAG_W-1:0]  issue_cnt;
  logic [ABUS_W-1:0] abus_cnt;
  logic              xfer_on;
  logic [BANK_W-1:0] xfer_bank;
  logic [BEAT_W-1:0] beat_cnt;
  logic [DATA_W-1:0] mem [DEPTH];

  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic              accept, xfer_last, bus_open, grant, gnt_any;
  logic [BANK_W-1:0] gnt_bank;
  logic [NBANKS-1:0] bank_free, on_bus;
  logic [IDX_W-1:0]  rd_idx;

  assign req_bank  = req_addr[BANK_W-1:0];
  assign req_row   = req_addr[ADDR_W-1:BANK_W];
  assign xfer_last = xfer_on && (beat_cnt == BEAT_W'(T_XFER - 1));
  assign bus_open  = !xfer_on || xfer_last;
  assign req_ready = (abus_cnt == '0) && bank_free[req_bank];
  assign accept    = req_valid && req_ready;
  assign grant     = bus_open && gnt_any;

  always_comb begin
    for (int b = 0; b < NBANKS; b++) begin
      on_bus[b]    = (phase[b] == PH_XFER);
      bank_free[b] = (phase[b] == PH_IDLE) || (xfer_last && xfer_bank == BANK_W'(b));
    end
  end

  always_comb begin
    logic [TAG_W-1:0] best, age;
    gnt_any  = 1'b0;
    gnt_bank = '0;
    best     = '0;
    for (int b = 0; b < NBANKS; b++) begin
      age = issue_cnt - tag[b];
      if (phase[b] == PH_ROW && timer[b] == '0 && (!gnt_any || age > best)) begin
        gnt_any  = 1'b1;
        gnt_bank = BANK_W'(b);
        best     = age;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANKS; b++) begin
        phase[b]  <= PH_IDLE;
        timer[b]  <= '0;
        row_of[b] <= '0;
        tag[b]    <= '0;
      end
    end else begin
      for (int b = 0; b < NBANKS; b++) begin
        if (accept && req_bank == BANK_W'(b)) begin
          phase[b]  <= PH_ROW;
          timer[b]  <= TMR_W'(T_ADDR + T_ROW - 1);
          row_of[b] <= req_row;
          tag[b]    <= issue_cnt;
        end else if (grant && gnt_bank == BANK_W'(b)) begin
          phase[b] <= PH_XFER;
        end else if (xfer_last && xfer_bank == BANK_W'(b)) begin
          phase[b] <= PH_IDLE;
        end else if (phase[b] == PH_ROW && timer[b] != '0) begin
          timer[b] <= timer[b] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_cnt <= '0;
      abus_cnt  <= '0;
    end else begin
      if (accept) issue_cnt <= issue_cnt + 1'b1;
      if (accept) abus_cnt <= ABUS_W'(T_ADDR - 1);
      else if (abus_cnt != '0) abus_cnt <= abus_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_on   <= 1'b0;
      xfer_bank <= '0;
      beat_cnt  <= '0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_beats <= '0;
    end else begin
      rsp_valid <= xfer_last;
      if (xfer_last) begin
        rsp_addr  <= {row_of[xfer_bank], xfer_bank};
        rsp_beats <= CNT_W'(beat_cnt) + CNT_W'(1);
      end
      if (grant) begin
        xfer_on   <= 1'b1;
        xfer_bank <= gnt_bank;
        beat_cnt  <= '0;
      end else if (xfer_last) begin
        xfer_on <= 1'b0;
      end else if (xfer_on) begin
        beat_cnt <= beat_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(i) ^ SALT;
    end
  end

  assign rd_idx     = IDX_W'({row_of[xfer_bank], xfer_bank}) * IDX_W'(T_XFER) + IDX_W'(beat_cnt);
  assign beat_valid = xfer_on;
  assign beat_data  = mem[rd_idx];

  AST_ONE_BANK_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(on_bus)); // R6
  AST_BEAT_FROM_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> on_bus[xfer_bank]); // R6
  AST_RSP_AFTER_LAST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(beat_valid) && $past(beat_cnt) == BEAT_W'(T_XFER - 1))); // R7
  AST_BEATS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_cnt != BEAT_W'(T_XFER - 1)) |=> (beat_valid && beat_cnt == $past(beat_cnt) + 1'b1)); // R4

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank_chk
    AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (phase[g] == PH_ROW && timer[g] != '0) |=> !on_bus[g]); // R3
  end

endmodule

// File: tb/ilv_bank_seq_test.sv
module ilv_bank_seq_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NB = 8;
  localparam int TA = 1, TR = 10, TX = 4;
  localparam int MAXC = 40000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, beat_valid, rsp_valid;
  logic [DW-1:0] beat_data;
  logic [AW-1:0] rsp_addr;
  logic [2:0] rsp_beats;

  ilv_bank_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .beat_valid(beat_valid), .beat_data(beat_data),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_beats(rsp_beats)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit exp_bv [MAXC];
  logic [DW-1:0] exp_bd [MAXC];
  bit exp_rv [MAXC];
  logic [AW-1:0] exp_ra [MAXC];
  int bank_free [NB];
  int bus_free = 0;
  int rsp_cyc [64];
  bit took;

  function automatic logic [DW-1:0] word(int a, int k);
    return DW'(a * TX + k) ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic model_accept(input int a, input int edge_t);
    int b, s;
    b = a % NB;
    s = edge_t + TA + TR;
    if (bus_free > s) s = bus_free;
    for (int k = 0; k < TX; k++) begin
      exp_bv[s + k] = 1'b1;
      exp_bd[s + k] = word(a, k);
    end
    exp_rv[s + TX] = 1'b1;
    exp_ra[s + TX] = AW'(a);
    bus_free = s + TX;
    bank_free[b] = s + TX;
  endtask

  task automatic check_outputs();
    check(beat_valid == exp_bv[cyc], "R3 R6 beat_valid", beat_valid, exp_bv[cyc]);
    if (exp_bv[cyc]) check(beat_data == exp_bd[cyc], "R4 beat_data", beat_data, exp_bd[cyc]);
    check(rsp_valid == exp_rv[cyc], "R7 rsp_valid", rsp_valid, exp_rv[cyc]);
    if (exp_rv[cyc] && rsp_valid) begin
      check(rsp_addr == exp_ra[cyc], "R1 R7 rsp_addr", rsp_addr, exp_ra[cyc]);
      check(rsp_beats == 3'(TX), "R7 rsp_beats", rsp_beats, TX);
      rsp_cyc[rsp_addr] = cyc;
    end
  endtask

  task automatic tick(input bit v, input logic [AW-1:0] a);
    bit exp_rdy;
    @(negedge clk);
    check_outputs();
    req_valid = v;
    req_addr = a;
    #1;
    exp_rdy = (cyc + 1) >= bank_free[a % NB];
    check(req_ready == exp_rdy, "R2 R5 R8 req_ready", req_ready, exp_rdy);
    took = v && req_ready;
    if (took) model_accept(int'(a), cyc + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, req_addr);
  endtask

  task automatic stream(input int base, input int step, output int first_edge);
    first_edge = -1;
    for (int i = 0; i < 8; i++) begin
      took = 1'b0;
      while (!took) begin
        tick(1'b1, AW'(base + i * step));
        if (took && first_edge < 0) first_edge = cyc + 1;
      end
    end
  endtask

  bit done = 1'b0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual %0d expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int fe;
    bit v;
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) bank_free[b] = 0;
    repeat (3) begin
      @(negedge clk);
      check(req_ready == 1'b1, "R10 reset req_ready", req_ready, 1);
      check(beat_valid == 1'b0, "R10 reset beat_valid", beat_valid, 0);
      check(rsp_valid == 1'b0, "R10 reset rsp_valid", rsp_valid, 0);
    end
    rst_n = 1'b1;
    idle(2);

    // R9 distinct banks, R5 back-to-back
    stream(16, 1, fe);
    idle(60);
    check(rsp_cyc[23] - fe == 43, "R9 eight-bank burst span", rsp_cyc[23] - fe, 43);

    // R9 R8 single bank stream
    stream(3, 8, fe);
    idle(30);
    check(rsp_cyc[59] - fe == 120, "R9 single-bank span", rsp_cyc[59] - fe, 120);

    // R1 top and bottom of address space
    stream(56, 1, fe);
    idle(60);
    check(rsp_cyc[63] - fe == 43, "R1 R9 burst at top of space", rsp_cyc[63] - fe, 43);

    a = '0;
    v = 1'b0;
    for (int i = 0; i < 12000; i++) begin
      if (!v || took) begin
        v = ($urandom % 5) != 0;
        a = ($urandom % 2) ? AW'(a + 1) : AW'($urandom);
      end
      tick(v, a);
    end
    idle(200);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule